// File: doc/BRIEF.md
# Eight-Channel Down-Counting Timer Bank with Toggle Output

This block holds a set of independent down-counters behind one 32-bit register bus. Each channel can act as a periodic tick source that raises an interrupt every time its counter runs out. It can also drive a square-wave output whose low and high widths come from two separate reload values. Software programs a channel by writing its reload values and then setting its enable bit. It reads the live count or the interrupt flags whenever it needs them, and it acknowledges interrupts by reading a clear register.

Each channel has a block of five words at a stride of 0x14 bytes: first reload, live count, control, clear, masked status. The second reload of channel n sits at 0xB0 + 4n. Four shared words hold the combined masked status (0xA0), a clear for every channel (0xA4), the raw flags (0xA8) and a read-only version word (0xAC). The two reload values give widths of (value + 1) clocks, so no phase can be shorter than one clock. A full-off or full-on output is therefore impossible, and every enable starts with the low phase.

Top module: `pwm_timer_bank`

## Requirements
- R1: Channel n's first reload reads back at n*0x14+0x00, its live count at +0x04, its control at +0x08 (bits 3:0 only, upper bits read 0) and its second reload at 0xB0+4n; address 0xAC reads the VERSION parameter (default 0x0001_0200); writes to count, status and clear addresses change nothing.
- R2: Control bit 0 enables the channel, bit 1 picks the reload source (1 = reload from the reload registers, 0 = free-running), bit 2 masks the interrupt, bit 3 selects toggle-output mode.
- R3: A write that turns the enable bit from 0 to 1 loads the counter with the first reload value and puts the output in its low phase on the next cycle.
- R4: In reload mode without toggle output, the counter steps down by one per clock, and on the clock after it reaches 0 it reloads the first reload value, so it expires every (first reload + 1) clocks.
- R5: In free-running mode the counter reloads with all ones (0xFFFF_FFFF) on expiry.
- R6: In toggle mode the output stays low for (first reload + 1) clocks, then high for (second reload + 1) clocks, and repeats. A value of 0 in both gives a one-clock alternation.
- R7: While the enable bit is 0, the counter holds its value and the toggle output is low.
- R8: Each expiry sets the channel's raw flag, seen at bit n of address 0xA8.
- R9: A channel's interrupt output, its status word (+0x10, bit 0) and bit n of 0xA0 equal the raw flag ANDed with the inverted mask bit.
- R10: Reading a channel's clear address (+0x0C) returns 0 and clears that channel's raw flag; an expiry in the same cycle wins.
- R11: Reading 0xA4 returns 0 and clears the raw flags of every channel.
- R12: A reload value written while the channel runs does not disturb the current count; it is used from the next reload on.
- R13: After reset every register reads 0 (except the version word), and all toggle and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | AW (8) | Byte address of the register access |
| bus_wr_i | input | 1 | Write strobe, one cycle per write |
| bus_rd_i | input | 1 | Read strobe; needed for the clear-on-read addresses |
| bus_wdata_i | input | DW (32) | Write data |
| bus_rdata_o | output | DW (32) | Read data for the current address (combinational) |
| pwm_o | output | NCH (8) | Toggle output per channel |
| irq_o | output | NCH (8) | Masked interrupt per channel |

## Verification
The toggle output is driven with an unequal low/high pair (2 and 4) and with the minimum pair (0 and 0). Sampling every clock against a computed waveform separates an off-by-one in either phase, a swapped phase order and a wrong starting phase. The periodic mode is run with a short reload, and the interrupt edge is checked at exactly the fourth and fifth cycles. Free-running mode is run next to the reload mode, which exposes a wrong reload source. A reload written mid-count, followed by reads of the live count before and after expiry, shows whether the new value leaks in early. Mask, per-channel clear and global clear are run on flags from several channels, which shows whether a clear reaches too few or too many channels.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
   localparam int STRIDE      = 'h14;
   localparam int OFF_LD1     = 'h00;
   localparam int OFF_CNT     = 'h04;
   localparam int OFF_CTRL    = 'h08;
   localparam int OFF_CLR     = 'h0C;
   localparam int OFF_STAT    = 'h10;
   localparam int ADR_GSTAT   = 'hA0;
   localparam int ADR_GCLR    = 'hA4;
   localparam int ADR_GRAW    = 'hA8;
   localparam int ADR_VER     = 'hAC;
   localparam int ADR_LD2     = 'hB0;

   // control word, bit 3 down to bit 0
   typedef struct packed {
      logic toggle;
      logic mask;
      logic user;
      logic en;
   } ctrl_t;
endpackage

// File: rtl/ptb_channel.sv
module ptb_channel
   import ptb_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          wr_ld1_i,
   input  logic          wr_ld2_i,
   input  logic          wr_ctrl_i,
   input  logic [DW-1:0] wdata_i,
   input  logic          clr_i,
   output logic [DW-1:0] ld1_o,
   output logic [DW-1:0] ld2_o,
   output ctrl_t         ctrl_o,
   output logic [DW-1:0] cnt_o,
   output logic          raw_o,
   output logic          start_o,
   output logic          expire_o,
   output logic          pwm_o
);
   logic          high_q;
   logic [DW-1:0] reload;

   assign start_o  = wr_ctrl_i & wdata_i[0] & ~ctrl_o.en;
   assign expire_o = ctrl_o.en & (cnt_o == '0);

   always_comb begin
      if (!ctrl_o.user)                 reload = '1;
      else if (ctrl_o.toggle && !high_q) reload = ld2_o;
      else                              reload = ld1_o;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ld1_o  <= '0;
         ld2_o  <= '0;
         ctrl_o <= '0;
      end else begin
         if (wr_ld1_i)  ld1_o  <= wdata_i;
         if (wr_ld2_i)  ld2_o  <= wdata_i;
         if (wr_ctrl_i) ctrl_o <= ctrl_t'(wdata_i[3:0]);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_o  <= '0;
         high_q <= 1'b0;
      end else if (start_o) begin
         cnt_o  <= ld1_o;
         high_q <= 1'b0;
      end else if (ctrl_o.en) begin
         if (expire_o) begin
            cnt_o <= reload;
            if (ctrl_o.toggle) high_q <= ~high_q;
         end else begin
            cnt_o <= cnt_o - 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       raw_o <= 1'b0;
      else if (expire_o) raw_o <= 1'b1;
      else if (clr_i)    raw_o <= 1'b0;
   end

   assign pwm_o = ctrl_o.en & ctrl_o.toggle & high_q;
endmodule

// File: rtl/ptb_readmux.sv
module ptb_readmux
   import ptb_pkg::*;
#(
   parameter int          NCH     = 8,
   parameter int          DW      = 32,
   parameter int          AW      = 8,
   parameter logic [31:0] VERSION = 32'h0001_0200
) (
   input  logic [AW-1:0]           addr_i,
   input  logic [NCH-1:0][DW-1:0]  ld1_i,
   input  logic [NCH-1:0][DW-1:0]  ld2_i,
   input  logic [NCH-1:0][DW-1:0]  cnt_i,
   input  logic [NCH-1:0][3:0]     ctrl_i,
   input  logic [NCH-1:0]          stat_i,
   input  logic [NCH-1:0]          raw_i,
   output logic [DW-1:0]           rdata_o,
   output logic [NCH-1:0]          clr_hit_o,
   output logic                    gclr_hit_o
);
   always_comb begin
      rdata_o    = '0;
      clr_hit_o  = '0;
      gclr_hit_o = (addr_i == AW'(ADR_GCLR));
      if (addr_i == AW'(ADR_GSTAT)) rdata_o = DW'(stat_i);
      if (addr_i == AW'(ADR_GRAW))  rdata_o = DW'(raw_i);
      if (addr_i == AW'(ADR_VER))   rdata_o = DW'(VERSION);
      for (int n = 0; n < NCH; n++) begin
         if (addr_i == AW'(n*STRIDE + OFF_LD1))  rdata_o = ld1_i[n];
         if (addr_i == AW'(n*STRIDE + OFF_CNT))  rdata_o = cnt_i[n];
         if (addr_i == AW'(n*STRIDE + OFF_CTRL)) rdata_o = DW'(ctrl_i[n]);
         if (addr_i == AW'(n*STRIDE + OFF_STAT)) rdata_o = DW'(stat_i[n]);
         if (addr_i == AW'(ADR_LD2 + 4*n))       rdata_o = ld2_i[n];
         clr_hit_o[n] = (addr_i == AW'(n*STRIDE + OFF_CLR));
      end
   end
endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
   import ptb_pkg::*;
#(
   parameter int          NCH     = 8,
   parameter int          DW      = 32,
   parameter int          AW      = 8,
   parameter logic [31:0] VERSION = 32'h0001_0200
) (
   input  logic           clk_i,
   input  logic           rst_ni,
   input  logic [AW-1:0]  bus_addr_i,
   input  logic           bus_wr_i,
   input  logic           bus_rd_i,
   input  logic [DW-1:0]  bus_wdata_i,
   output logic [DW-1:0]  bus_rdata_o,
   output logic [NCH-1:0] pwm_o,
   output logic [NCH-1:0] irq_o
);
   localparam int TOP_ADR = ADR_LD2 + 4*NCH;

   if (NCH < 1 || NCH*STRIDE > ADR_GSTAT) begin : g_bad_nch
      $error("NCH must fit below the shared register block");
   end
   if (DW < 8 || DW > 32) begin : g_bad_dw
      $error("DW must lie between 8 and 32");
   end
   if (TOP_ADR > (1 << AW)) begin : g_bad_aw
      $error("AW too narrow for the register map");
   end

   logic [NCH-1:0][DW-1:0] chan_ld1, chan_ld2, chan_cnt;
   logic [NCH-1:0][3:0]    chan_ctrl;
   logic [NCH-1:0]         chan_en, chan_mask, chan_raw, chan_stat;
   logic [NCH-1:0]         chan_start, chan_expire, chan_clr, clr_hit;
   logic                   gclr_hit;

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      ctrl_t ctrl;
      logic  wr_ld1, wr_ld2, wr_ctrl;

      assign wr_ld1  = bus_wr_i & (bus_addr_i == AW'(n*STRIDE + OFF_LD1));
      assign wr_ctrl = bus_wr_i & (bus_addr_i == AW'(n*STRIDE + OFF_CTRL));
      assign wr_ld2  = bus_wr_i & (bus_addr_i == AW'(ADR_LD2 + 4*n));
      assign chan_clr[n] = bus_rd_i & (clr_hit[n] | gclr_hit);

      ptb_channel #(.DW(DW)) u_ch (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .wr_ld1_i (wr_ld1),
         .wr_ld2_i (wr_ld2),
         .wr_ctrl_i(wr_ctrl),
         .wdata_i  (bus_wdata_i),
         .clr_i    (chan_clr[n]),
         .ld1_o    (chan_ld1[n]),
         .ld2_o    (chan_ld2[n]),
         .ctrl_o   (ctrl),
         .cnt_o    (chan_cnt[n]),
         .raw_o    (chan_raw[n]),
         .start_o  (chan_start[n]),
         .expire_o (chan_expire[n]),
         .pwm_o    (pwm_o[n])
      );

      assign chan_ctrl[n] = ctrl;
      assign chan_en[n]   = ctrl.en;
      assign chan_mask[n] = ctrl.mask;
      assign chan_stat[n] = chan_raw[n] & ~ctrl.mask;
   end

   assign irq_o = chan_stat;

   ptb_readmux #(.NCH(NCH), .DW(DW), .AW(AW), .VERSION(VERSION)) u_rd (
      .addr_i    (bus_addr_i),
      .ld1_i     (chan_ld1),
      .ld2_i     (chan_ld2),
      .cnt_i     (chan_cnt),
      .ctrl_i    (chan_ctrl),
      .stat_i    (chan_stat),
      .raw_i     (chan_raw),
      .rdata_o   (bus_rdata_o),
      .clr_hit_o (clr_hit),
      .gclr_hit_o(gclr_hit)
   );
endmodule

// File: rtl/ptb_checker.sv
module ptb_checker #(
   parameter int NCH = 8,
   parameter int DW  = 32,
   parameter int AW  = 8
) (
   input logic                   clk_i,
   input logic                   rst_ni,
   input logic [AW-1:0]          bus_addr_i,
   input logic                   bus_wr_i,
   input logic                   bus_rd_i,
   input logic [DW-1:0]          bus_rdata_o,
   input logic [NCH-1:0]         pwm_o,
   input logic [NCH-1:0]         irq_o,
   input logic [NCH-1:0]         chan_en,
   input logic [NCH-1:0]         chan_start,
   input logic [NCH-1:0]         chan_expire,
   input logic [NCH-1:0]         chan_raw,
   input logic [NCH-1:0]         chan_mask,
   input logic [NCH-1:0][DW-1:0] chan_cnt
);
   localparam logic [AW-1:0] GCLR = AW'('hA4);

   assert_geoi_zero_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && bus_addr_i == GCLR) |-> bus_rdata_o == '0);

   assert_gclr_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_rd_i && bus_addr_i == GCLR && chan_expire == '0) |=> chan_raw == '0);

   for (genvar n = 0; n < NCH; n++) begin : g_chk
      assert_off_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         !chan_en[n] |-> !pwm_o[n]);

      assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (!chan_en[n] && !chan_start[n]) |=> $stable(chan_cnt[n]));

      assert_start_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
         chan_start[n] |=> !pwm_o[n]);

      assert_rise_at_expiry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $rose(pwm_o[n]) |-> ($past(chan_expire[n]) || $past(bus_wr_i)));

      assert_irq_raw_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
         irq_o[n] |-> (chan_raw[n] && !chan_mask[n]));

      assert_expire_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
         chan_expire[n] |=> chan_raw[n]);
   end
endmodule

bind pwm_timer_bank ptb_checker #(.NCH(NCH), .DW(DW), .AW(AW)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .bus_addr_i (bus_addr_i),
   .bus_wr_i   (bus_wr_i),
   .bus_rd_i   (bus_rd_i),
   .bus_rdata_o(bus_rdata_o),
   .pwm_o      (pwm_o),
   .irq_o      (irq_o),
   .chan_en    (chan_en),
   .chan_start (chan_start),
   .chan_expire(chan_expire),
   .chan_raw   (chan_raw),
   .chan_mask  (chan_mask),
   .chan_cnt   (chan_cnt)
);

// File: tb/sim_pwm_timer_bank.sv
module sim_pwm_timer_bank;
   localparam int NCH = 8;
   localparam int DW  = 32;
   localparam int AW  = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic           wr = 1'b0;
   logic           rd = 1'b0;
   logic [DW-1:0]  wdata = '0;
   logic [DW-1:0]  rdata;
   logic [NCH-1:0] pwm, irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   pwm_timer_bank #(.NCH(NCH), .DW(DW), .AW(AW)) u0 (
      .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
      .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
      .pwm_o(pwm), .irq_o(irq)
   );

   task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr_reg(int a, logic [DW-1:0] d);
      addr = AW'(a); wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_reg(int a, output logic [DW-1:0] d);
      addr = AW'(a); rd = 1'b1;
      #1 d = rdata;
      @(negedge clk);
      rd = 1'b0;
   endtask

   function automatic int base(int n); return n * 'h14; endfunction

   task automatic t_reset();
      logic [DW-1:0] v;
      check("R13 pwm", DW'(pwm), 0);
      check("R13 irq", DW'(irq), 0);
      rd_reg(base(0) + 8, v); check("R13 ctrl", v, 0);
      rd_reg(base(3), v);     check("R13 ld1", v, 0);
      rd_reg('hA8, v);        check("R13 raw", v, 0);
      rd_reg('hAC, v);        check("R1 version", v, 32'h0001_0200);
   endtask

   task automatic t_regs();
      logic [DW-1:0] v;
      wr_reg(base(5), 32'hDEAD_BEEF);
      wr_reg('hB0 + 4*5, 32'h1234_5678);
      wr_reg(base(5) + 8, 32'hFFFF_FFF6);
      wr_reg(base(5) + 4, 32'h0000_0055);
      rd_reg(base(5), v);      check("R1 ld1 readback", v, 32'hDEAD_BEEF);
      rd_reg('hB0 + 4*5, v);   check("R1 ld2 readback", v, 32'h1234_5678);
      rd_reg(base(5) + 8, v);  check("R2 ctrl 4 bits", v, 32'h6);
      rd_reg(base(5) + 4, v);  check("R1 count not writable", v, 0);
      wr_reg(base(5) + 8, 0);
   endtask

   task automatic t_pwm(int ch, int lo, int hi, int n);
      int bad = 0;
      logic e;
      wr_reg(base(ch), DW'(lo));
      wr_reg('hB0 + 4*ch, DW'(hi));
      wr_reg(base(ch) + 8, 32'hB);
      for (int k = 0; k < n; k++) begin
         e = ((k % (lo + hi + 2)) > lo);
         if (pwm[ch] !== e) begin
            bad++;
            $display("FAIL R6 ch%0d cycle %0d: actual %0b expected %0b", ch, k, pwm[ch], e);
         end
         @(negedge clk);
      end
      checks++;
      if (bad != 0) fails++;
      wr_reg(base(ch) + 8, 32'hA);
      check("R7 disabled output low", DW'(pwm[ch]), 0);
   endtask

   task automatic t_irq();
      logic [DW-1:0] v;
      wr_reg(base(2), 3);
      wr_reg(base(2) + 8, 32'h3);
      @(negedge clk); @(negedge clk); @(negedge clk);
      check("R4 no irq before expiry", DW'(irq[2]), 0);
      @(negedge clk);
      check("R8 irq at expiry", DW'(irq[2]), 1);
      wr_reg(base(2) + 8, 32'h7);
      check("R9 masked irq low", DW'(irq[2]), 0);
      rd_reg('hA8, v);       check("R8 raw bit", v & 32'h4, 32'h4);
      rd_reg('hA0, v);       check("R9 combined masked", v & 32'h4, 0);
      rd_reg(base(2) + 'h10, v); check("R9 status masked", v, 0);
      wr_reg(base(2) + 8, 32'h2);
      check("R9 unmasked irq", DW'(irq[2]), 1);
      rd_reg(base(2) + 'h10, v); check("R9 status unmasked", v, 1);
      rd_reg(base(2) + 'hC, v);  check("R10 clear reads zero", v, 0);
      rd_reg('hA8, v);           check("R10 flag cleared", v & 32'h4, 0);
      check("R10 irq dropped", DW'(irq[2]), 0);
   endtask

   task automatic t_free();
      logic [DW-1:0] v;
      wr_reg(base(4), 5);
      wr_reg(base(4) + 8, 32'h1);
      repeat (6) @(negedge clk);
      rd_reg(base(4) + 4, v); check("R5 reload all ones", v, 32'hFFFF_FFFF);
      rd_reg(base(4) + 4, v); check("R5 counts down", v, 32'hFFFF_FFFE);
      wr_reg(base(4) + 8, 0);
   endtask

   task automatic t_reload();
      logic [DW-1:0] v, w;
      wr_reg(base(1), 9);
      wr_reg(base(1) + 8, 32'h3);
      @(negedge clk); @(negedge clk);
      wr_reg(base(1), 3);
      rd_reg(base(1) + 4, v); check("R12 count undisturbed", v, 6);
      repeat (6) @(negedge clk);
      rd_reg(base(1) + 4, v); check("R4 R12 reload new value", v, 3);
      wr_reg(base(1) + 8, 32'h2);
      rd_reg(base(1) + 4, v);
      repeat (3) @(negedge clk);
      rd_reg(base(1) + 4, w); check("R7 count holds", w, v);
   endtask

   task automatic t_gclr();
      logic [DW-1:0] v;
      rd_reg('hA8, v); check("R8 raw flags of run channels", v, 32'h1B);
      rd_reg('hA4, v); check("R11 global clear reads zero", v, 0);
      rd_reg('hA8, v); check("R11 all flags cleared", v, 0);
      check("R11 irqs low", DW'(irq), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_pwm(0, 2, 4, 30);
      t_pwm(3, 0, 0, 12);
      t_irq();
      t_free();
      t_reload();
      t_gclr();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule